// File: doc/BRIEF.md
# USB Device Endpoint Transaction Sequencer

This block is the device-side control logic that walks a single endpoint through USB transactions. Upstream logic supplies decoded tokens (packet identifier, endpoint number and a token CRC verdict), decoded data packets (identifier, CRC16 verdict and byte length) and host handshakes. The application supplies two level flags: whether the endpoint buffer is ready, and whether the endpoint is halted. For each event the sequencer decides, one clock later, whether to commit received data, start sending data, return ACK, NAK or STALL, or stay silent. It also keeps the DATA0/DATA1 toggle.

The endpoint kind is an input: control (0), isochronous (1), bulk (2) or interrupt (3). Isochronous traffic has no handshake phase and no toggle. A SETUP may not be refused. A SETUP also restarts the toggle, so that the control stages that follow start from a known value. When a stage waits for a data packet or for a host handshake and none arrives within `TIMEOUT` cycles, the sequencer gives up the wait and returns to idle.

All 4-bit identifiers use the standard codes: OUT 4'b0001, IN 4'b1001, SETUP 4'b1101, DATA0 4'b0011, DATA1 4'b1011, ACK 4'b0010, NAK 4'b1010, STALL 4'b1110.

Top module: `usb_txn_seq`

## Requirements
- R1: While `rst_n` is low and after its release, all strobes (`hs_tx_valid`, `dtx_valid`, `rx_accept`, `rx_setup`, `tx_done`) are 0, `data_tgl` is 0 and the sequencer is idle.
- R2: A token is ignored if `tok_crc_ok` is 0, if `tok_ep` differs from `EP_NUM`, or if it is a SETUP (4'b1101) while `ep_kind` is not control (0). A data packet that then arrives produces no output.
- R3: After a SETUP token (4'b1101) on a control endpoint, `data_tgl` is 0. An error-free data packet that follows is accepted (`rx_accept`=1, `rx_setup`=1) and answered with ACK (4'b0010), whatever the ready and stall flags. `data_tgl` then becomes 1.
- R4: On an OUT (4'b0001) on a non-isochronous endpoint that is ready and not halted, a good data packet whose identifier matches the toggle (DATA0 4'b0011 for toggle 0, DATA1 4'b1011 for toggle 1) is accepted and answered with ACK, and the toggle flips.
- R5: On such an OUT, a good data packet whose identifier does not match the toggle is treated as a retransmission. It is answered with ACK, is not accepted, and leaves the toggle unchanged.
- R6: On a non-isochronous OUT with good data, a halted endpoint gets STALL (4'b1110), which takes precedence. Otherwise a matching packet on an endpoint that is not ready gets NAK (4'b1010). In both cases the toggle is unchanged and nothing is accepted.
- R7: A data packet with `dat_crc_ok`=0, with `dat_len` greater than `MAX_LEN`, or with an identifier that is neither DATA0 nor DATA1 gets no response: no handshake, no accept, and the toggle is unchanged.
- R8: On an IN (4'b1001) on a non-isochronous endpoint, the response is STALL if the endpoint is halted, else NAK if it is not ready, else a data start (`dtx_valid`) with DATA0 or DATA1 chosen by the toggle.
- R9: After sending data for an IN, a host ACK flips the toggle and pulses `tx_done`. Any other host handshake, or none within `TIMEOUT` cycles, leaves the toggle unchanged and gives no `tx_done`, so a retry resends the same identifier.
- R10: On an isochronous endpoint no handshake is ever sent and the toggle never changes. An IN that is ready and not halted sends DATA0 and pulses `tx_done` at once. An OUT with good data is accepted when the endpoint is ready and not halted.
- R11: If no data packet follows an accepted OUT or SETUP token within `TIMEOUT` cycles, the sequencer returns to idle. A data packet that arrives later gets no response.
- R12: Every response appears on the outputs exactly one clock after the strobe that causes it, lasts one cycle, and `hs_tx_valid` and `dtx_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_kind | input | 2 | Endpoint kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| tok_valid | input | 1 | Decoded token strobe |
| tok_pid | input | 4 | Token identifier |
| tok_ep | input | 4 | Token endpoint number |
| tok_crc_ok | input | 1 | Token CRC5 good |
| dat_valid | input | 1 | Decoded data packet strobe (end of packet) |
| dat_pid | input | 4 | Data packet identifier |
| dat_crc_ok | input | 1 | Data CRC16 good |
| dat_len | input | 11 | Payload length in bytes |
| hs_valid | input | 1 | Host handshake strobe |
| hs_pid | input | 4 | Host handshake identifier |
| ep_ready | input | 1 | Application buffer ready |
| ep_stall | input | 1 | Endpoint halted |
| hs_tx_valid | output | 1 | Send a handshake |
| hs_tx_pid | output | 4 | Handshake identifier to send |
| dtx_valid | output | 1 | Start sending a data packet |
| dtx_pid | output | 4 | Data identifier to send |
| rx_accept | output | 1 | Commit the received payload |
| rx_setup | output | 1 | Committed payload is SETUP data |
| tx_done | output | 1 | Transmitted payload delivered, release it |
| data_tgl | output | 1 | Current data toggle |

## Verification
A wrong toggle shows at the ports on the next data exchange: an OUT that should be committed is acknowledged but dropped, or a fresh one is committed twice, or an IN goes out with the wrong identifier. `data_tgl` also shows the error one cycle after the strobe that caused it. A state that is stuck in a wait shows as a missing handshake on the next data packet, or as a spurious response to a late one. The checks sample one cycle after every strobe, so each such fault shows on the transaction that causes it.

// File: rtl/usb_txn_seq.sv
module usb_txn_seq #(
  parameter int EP_NUM  = 1,
  parameter int TIMEOUT = 16,
  parameter int MAX_LEN = 1024,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ep_kind,
  input  logic          tok_valid,
  input  logic [3:0]    tok_pid,
  input  logic [3:0]    tok_ep,
  input  logic          tok_crc_ok,
  input  logic          dat_valid,
  input  logic [3:0]    dat_pid,
  input  logic          dat_crc_ok,
  input  logic [LW-1:0] dat_len,
  input  logic          hs_valid,
  input  logic [3:0]    hs_pid,
  input  logic          ep_ready,
  input  logic          ep_stall,
  output logic          hs_tx_valid,
  output logic [3:0]    hs_tx_pid,
  output logic          dtx_valid,
  output logic [3:0]    dtx_pid,
  output logic          rx_accept,
  output logic          rx_setup,
  output logic          tx_done,
  output logic          data_tgl
);
  localparam logic [3:0] P_OUT = 4'b0001, P_IN = 4'b1001, P_SETUP = 4'b1101;
  localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011;
  localparam logic [3:0] P_ACK = 4'b0010, P_NAK = 4'b1010, P_STALL = 4'b1110;
  localparam logic [1:0] K_CTL = 2'd0, K_ISO = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_HS} st_t;

  st_t           st;
  logic          setup_q;
  logic [CW-1:0] cnt;

  wire is_iso  = ep_kind == K_ISO;
  wire tok_hit = tok_valid && tok_crc_ok && tok_ep == 4'(EP_NUM);
  wire dat_ok  = dat_crc_ok && 32'(dat_len) <= MAX_LEN && (dat_pid == P_D0 || dat_pid == P_D1);
  wire [3:0] tgl_pid = data_tgl ? P_D1 : P_D0;
  wire can_move = ep_ready && !ep_stall;
  wire expired  = 32'(cnt) >= TIMEOUT - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      setup_q     <= 1'b0;
      cnt         <= '0;
      data_tgl    <= 1'b0;
      hs_tx_valid <= 1'b0;
      hs_tx_pid   <= P_ACK;
      dtx_valid   <= 1'b0;
      dtx_pid     <= P_D0;
      rx_accept   <= 1'b0;
      rx_setup    <= 1'b0;
      tx_done     <= 1'b0;
    end else begin
      hs_tx_valid <= 1'b0;
      dtx_valid   <= 1'b0;
      rx_accept   <= 1'b0;
      rx_setup    <= 1'b0;
      tx_done     <= 1'b0;
      case (st)
        S_IDLE: if (tok_hit) begin
          cnt <= '0;
          case (tok_pid)
            P_SETUP: if (ep_kind == K_CTL) begin
              data_tgl <= 1'b0;
              setup_q  <= 1'b1;
              st       <= S_DATA;
            end
            P_OUT: begin
              setup_q <= 1'b0;
              st      <= S_DATA;
            end
            P_IN: begin
              if (is_iso) begin
                if (can_move) begin
                  dtx_valid <= 1'b1;
                  dtx_pid   <= P_D0;
                  tx_done   <= 1'b1;
                end
              end else if (ep_stall) begin
                hs_tx_valid <= 1'b1;
                hs_tx_pid   <= P_STALL;
              end else if (!ep_ready) begin
                hs_tx_valid <= 1'b1;
                hs_tx_pid   <= P_NAK;
              end else begin
                dtx_valid <= 1'b1;
                dtx_pid   <= tgl_pid;
                st        <= S_HS;
              end
            end
            default: ;
          endcase
        end
        S_DATA: begin
          if (dat_valid) begin
            st <= S_IDLE;
            if (dat_ok) begin
              if (setup_q) begin
                rx_accept   <= 1'b1;
                rx_setup    <= 1'b1;
                hs_tx_valid <= 1'b1;
                hs_tx_pid   <= P_ACK;
                data_tgl    <= 1'b1;
              end else if (is_iso) begin
                rx_accept <= can_move;
              end else if (ep_stall) begin
                hs_tx_valid <= 1'b1;
                hs_tx_pid   <= P_STALL;
              end else if (dat_pid != tgl_pid) begin
                hs_tx_valid <= 1'b1;
                hs_tx_pid   <= P_ACK;
              end else if (!ep_ready) begin
                hs_tx_valid <= 1'b1;
                hs_tx_pid   <= P_NAK;
              end else begin
                rx_accept   <= 1'b1;
                hs_tx_valid <= 1'b1;
                hs_tx_pid   <= P_ACK;
                data_tgl    <= ~data_tgl;
              end
            end
          end else if (expired) begin
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HS: begin
          if (hs_valid) begin
            st <= S_IDLE;
            if (hs_pid == P_ACK) begin
              data_tgl <= ~data_tgl;
              tx_done  <= 1'b1;
            end
          end else if (expired) begin
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_txn_seq_chk.sv
module usb_txn_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ep_kind,
  input logic       tok_valid,
  input logic       dat_valid,
  input logic       dat_crc_ok,
  input logic       hs_valid,
  input logic [3:0] hs_pid,
  input logic       hs_tx_valid,
  input logic [3:0] hs_tx_pid,
  input logic       dtx_valid,
  input logic       rx_accept,
  input logic       rx_setup,
  input logic       tx_done,
  input logic       data_tgl
);
  // R12
  tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hs_tx_valid, dtx_valid}) <= 1);

  // R7
  crc_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dat_valid && !dat_crc_ok && !tok_valid && !hs_valid) |-> !hs_tx_valid && !rx_accept);

  // R10
  iso_no_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_tx_valid |-> $past(ep_kind) != 2'd1);

  // R3
  setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_setup |-> rx_accept && hs_tx_valid && hs_tx_pid == 4'b0010);

  // R4
  accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> $past(dat_valid && dat_crc_ok));

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !dtx_valid |-> $past(hs_valid && hs_pid == 4'b0010));

  // R9
  tgl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_tgl != $past(data_tgl) |-> $past(tok_valid || dat_valid || hs_valid));
endmodule

bind usb_txn_seq usb_txn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ep_kind(ep_kind), .tok_valid(tok_valid),
  .dat_valid(dat_valid), .dat_crc_ok(dat_crc_ok), .hs_valid(hs_valid),
  .hs_pid(hs_pid), .hs_tx_valid(hs_tx_valid), .hs_tx_pid(hs_tx_pid),
  .dtx_valid(dtx_valid), .rx_accept(rx_accept), .rx_setup(rx_setup),
  .tx_done(tx_done), .data_tgl(data_tgl)
);

// File: tb/sim_usb_txn_seq.sv
module sim_usb_txn_seq;
  localparam int EP = 1, TMO = 16, MAXL = 1024;
  localparam logic [3:0] P_OUT = 4'b0001, P_IN = 4'b1001, P_SETUP = 4'b1101;
  localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011;
  localparam logic [3:0] P_ACK = 4'b0010, P_NAK = 4'b1010, P_STALL = 4'b1110;

  logic clk = 0, rst_n = 0;
  logic [1:0] ep_kind = 2;
  logic tok_valid = 0, tok_crc_ok = 0, dat_valid = 0, dat_crc_ok = 0, hs_valid = 0;
  logic [3:0] tok_pid = 0, tok_ep = 0, dat_pid = 0, hs_pid = 0;
  logic [10:0] dat_len = 0;
  logic ep_ready = 0, ep_stall = 0;
  logic hs_tx_valid, dtx_valid, rx_accept, rx_setup, tx_done, data_tgl;
  logic [3:0] hs_tx_pid, dtx_pid;

  int total = 0, fails = 0;
  bit exp_tgl = 0;

  always #2 clk = ~clk;

  usb_txn_seq #(.EP_NUM(EP), .TIMEOUT(TMO), .MAX_LEN(MAXL)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  function automatic logic [3:0] pid_of(bit t);
    return t ? P_D1 : P_D0;
  endfunction

  task automatic send_tok(logic [3:0] pid, logic [3:0] ep, logic ok);
    @(negedge clk);
    tok_valid = 1; tok_pid = pid; tok_ep = ep; tok_crc_ok = ok;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic send_dat(logic [3:0] pid, logic ok, int len);
    @(negedge clk);
    dat_valid = 1; dat_pid = pid; dat_crc_ok = ok; dat_len = 11'(len);
    @(negedge clk);
    dat_valid = 0;
  endtask

  task automatic send_hs(logic [3:0] pid);
    @(negedge clk);
    hs_valid = 1; hs_pid = pid;
    @(negedge clk);
    hs_valid = 0;
  endtask

  task automatic xfer_out(bit setup, logic [3:0] tep, bit tcrc, logic [3:0] dpid, bit dcrc, int len);
    bit tok_ok, good, ev, ea;
    logic [3:0] ep_;
    tok_ok = tcrc && tep == EP && (!setup || ep_kind == 0);
    send_tok(setup ? P_SETUP : P_OUT, tep, tcrc);
    chk("R12 no response to OUT/SETUP token", {hs_tx_valid, dtx_valid}, 0);
    if (setup && tok_ok) begin
      exp_tgl = 0;
      chk("R3 toggle cleared by SETUP", data_tgl, 0);
    end
    send_dat(dpid, dcrc, len);
    good = dcrc && len <= MAXL && (dpid == P_D0 || dpid == P_D1);
    ev = 0; ea = 0; ep_ = P_ACK;
    if (tok_ok && good) begin
      if (setup) begin ev = 1; ea = 1; exp_tgl = 1; end
      else if (ep_kind == 1) ea = ep_ready && !ep_stall;
      else if (ep_stall) begin ev = 1; ep_ = P_STALL; end
      else if (dpid != pid_of(exp_tgl)) ev = 1;
      else if (!ep_ready) begin ev = 1; ep_ = P_NAK; end
      else begin ev = 1; ea = 1; exp_tgl = ~exp_tgl; end
    end
    chk(!tok_ok ? "R2 ignored token, data silent" : !good ? "R7 bad data silent" :
        setup ? "R3 setup handshake" : "R4/R5/R6 OUT handshake valid", hs_tx_valid, ev);
    if (ev) chk(setup ? "R3 setup ACK" : "R4/R5/R6 OUT handshake pid", hs_tx_pid, ep_);
    chk(ep_kind == 1 ? "R10 iso OUT accept" : "R4/R5 OUT accept", rx_accept, ea);
    chk("R3 setup flag", rx_setup, ea && setup);
    chk("R5/R7 toggle after data", data_tgl, exp_tgl);
  endtask

  task automatic xfer_in(int hk);
    bit dv, hv, iso;
    logic [3:0] hp, dp;
    iso = ep_kind == 1;
    dv = 0; hv = 0; hp = P_NAK; dp = pid_of(exp_tgl);
    if (iso) begin dv = ep_ready && !ep_stall; dp = P_D0; end
    else if (ep_stall) begin hv = 1; hp = P_STALL; end
    else if (!ep_ready) hv = 1;
    else dv = 1;
    send_tok(P_IN, 4'(EP), 1);
    chk("R8 IN data start", dtx_valid, dv);
    chk(iso ? "R10 no handshake on iso" : "R8 IN handshake", hs_tx_valid, hv);
    if (hv) chk("R8 IN handshake pid", hs_tx_pid, hp);
    if (dv) chk(iso ? "R10 iso sends DATA0" : "R8 IN data pid", dtx_pid, dp);
    chk("R10 iso done at once", tx_done, iso && dv);
    if (dv && !iso) begin
      if (hk == 2) repeat (TMO + 2) @(negedge clk);
      else send_hs(hk == 0 ? P_ACK : P_NAK);
      if (hk == 0) exp_tgl = ~exp_tgl;
      chk("R9 tx_done after host handshake", tx_done, hk == 0);
      chk("R9 toggle after IN", data_tgl, exp_tgl);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed = $urandom(32'h1d5e);
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {hs_tx_valid, dtx_valid, rx_accept, rx_setup, tx_done}, 0);
    chk("R1 reset toggle", data_tgl, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {hs_tx_valid, dtx_valid, rx_accept, tx_done}, 0);

    ep_kind = 2; ep_ready = 1; ep_stall = 0;
    xfer_out(0, 4'(EP), 1, P_D0, 1, 64);            // R4
    xfer_out(0, 4'(EP), 1, P_D0, 1, 64);            // R5 retransmission
    xfer_out(0, 4'(EP), 0, P_D1, 1, 8);             // R2 bad token CRC
    xfer_out(0, 4'(EP + 1), 1, P_D1, 1, 8);         // R2 other endpoint
    xfer_out(1, 4'(EP), 1, P_D0, 1, 8);             // R2 SETUP on bulk
    xfer_out(0, 4'(EP), 1, P_D1, 0, 8);             // R7 CRC error
    xfer_out(0, 4'(EP), 1, P_D1, 1, MAXL + 1);      // R7 oversize
    xfer_out(0, 4'(EP), 1, P_D1, 1, MAXL);          // R4 max length
    ep_ready = 0;
    xfer_out(0, 4'(EP), 1, P_D0, 1, 0);             // R6 NAK
    ep_stall = 1;
    xfer_out(0, 4'(EP), 1, P_D0, 1, 0);             // R6 STALL
    ep_kind = 0; ep_ready = 0; ep_stall = 1;
    xfer_out(1, 4'(EP), 1, P_D0, 1, 8);             // R3 setup refused never
    ep_stall = 0; ep_ready = 1;
    xfer_in(2);                                     // R9 no handshake, DATA1 kept
    xfer_in(0);                                     // R9 same pid resent, then ACK
    // R11 timeout then late data
    send_tok(P_OUT, 4'(EP), 1);
    repeat (TMO + 4) @(negedge clk);
    send_dat(pid_of(exp_tgl), 1, 4);
    chk("R11 late data ignored", {hs_tx_valid, rx_accept}, 0);
    chk("R11 toggle kept", data_tgl, exp_tgl);

    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 3;
      ep_kind  = 2'($urandom % 4);
      ep_ready = ($urandom % 4) != 0;
      ep_stall = ($urandom % 6) == 0;
      if (op == 2) xfer_in($urandom % 3);
      else begin
        logic [3:0] dp = ($urandom % 2) ? P_D1 : P_D0;
        if (($urandom % 16) == 0) dp = P_ACK;
        xfer_out(op == 1, ($urandom % 10 == 0) ? 4'(EP + 2) : 4'(EP), ($urandom % 12) != 0,
                 dp, ($urandom % 8) != 0, ($urandom % 10 == 0) ? MAXL + 5 : int'($urandom % 513));
      end
      @(negedge clk);
    end
    if (seed == 0) $display("seed zero");
    summary();
  end
endmodule